// File: doc/BRIEF.md
# Microstep Current-Code Sequencer

This block sequences the coil currents of a two-phase bipolar stepper motor. It holds a 6-bit position index that spans one electrical cycle of 64 table steps. Each step strobe moves the index forward or backward by an amount set by a resolution input. From the index it decodes, for each coil, a 4-bit current-level code, a polarity bit and a coil-off bit. These outputs feed two chopper current regulators and their reference selectors, which are not part of this block.

The 64-step cycle has four quadrants of 16 steps each. Coil A follows a sine-shaped profile and coil B a cosine-shaped one. The current levels are non-linear: level code c gives a fraction k/11.5 of full scale. Codes 2 to 7 give k = 2 to 7. Codes 8 to 15 give k = 8, 8.5, 9, … 11.5, so code 15 is full scale.

Within a quadrant, position p runs from 0 to 15:
- At p = 0 the rising coil is switched off and the falling coil is at full scale.
- The rising coil takes code p+1 for p = 1 to 14, and code 15 at p = 15.
- The falling coil mirrors the rising coil, taking the rising code of position 16-p.

As a result, full scale is repeated at the quadrant ends, and both coils carry code 9 at p = 8.

Top module: `ustep_seq`

## Requirements
- R1: While reset is high, and after it is released until the first accepted step, the index is 0. Coil A is off with code 0000 and polarity 1. Coil B has code 1111 and polarity 1.
- R2: In each quadrant, the rising coil's code is 0 and its off bit is 1 at p=0. It is p+1 for p=1..14 and 15 at p=15. The falling coil's code equals the rising code of position 16-p, taking 15 at p=0. Quadrant = index[5:4] and p = index[3:0]. Coil A rises in quadrants 0 and 2. Coil B rises in quadrants 1 and 3.
- R3: At p=8 of any quadrant, both coils carry code 1001.
- R4: At p=0 exactly one coil is off (code 0000), and the other coil has code 1111. The two coils are never off at the same time.
- R5: The polarity bit (1 = positive) of coil A is 0 in quadrants 2 and 3. The polarity bit of coil B is 0 in quadrants 1 and 2. A coil's polarity changes only in a cycle where that coil is off or was off in the previous cycle.
- R6: Resolution input res_i selects the index increment per step: 00 → 8, 01 → 4, 10 → 2, 11 → 1.
- R7: dir_i = 1 adds the increment and dir_i = 0 subtracts it. The index wraps modulo 64 in both directions.
- R8: Whenever hold is low, the index is first rounded down to a multiple of the current increment in each clock, and then stepped. A resolution change therefore realigns the index one clock later.
- R9: While hold_i is high, the index does not change: step strobes and resolution changes have no effect on the outputs.
- R10: A step strobe sampled high at a rising edge updates all outputs directly after that same edge. The outputs hold their previous values before that edge.
- R11: Code 0001 is never produced, and a coil's off bit is 1 exactly when its code is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Step strobe, one step per cycle it is high |
| dir_i | input | 1 | 1 = forward, 0 = backward |
| hold_i | input | 1 | Freezes the index |
| res_i | input | 2 | Resolution select (increment 8/4/2/1) |
| a_code_o | output | 4 | Coil A current-level code |
| a_pol_o | output | 1 | Coil A polarity, 1 = positive |
| a_off_o | output | 1 | Coil A switched off |
| b_code_o | output | 4 | Coil B current-level code |
| b_pol_o | output | 1 | Coil B polarity, 1 = positive |
| b_off_o | output | 1 | Coil B switched off |

## Verification
The only register between the inputs and the outputs is the index. Every output therefore changes in the edge that samples a step strobe, and an index realignment appears one edge after the resolution changes. The bench drives inputs on falling edges and samples on the following falling edge. One rising edge, and so exactly one index update, lies in between. The bench also samples once just before an edge, to show that nothing moves early. A bench-side index model advances in the same clocks and is decoded against the stated code and polarity rules.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

    localparam int POS_W  = 4;                 // position within a quadrant
    localparam int QUAD_W = 2;                 // quadrant number
    localparam int IDX_W  = POS_W + QUAD_W;    // full electrical cycle
    localparam int CODE_W = 4;                 // current-level code
    localparam int X_W    = POS_W + 1;         // distance from zero, 0..2**POS_W
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    typedef enum logic [1:0] {
        RES_X8 = 2'b00,
        RES_X4 = 2'b01,
        RES_X2 = 2'b10,
        RES_X1 = 2'b11
    } res_t;

    typedef struct packed {
        logic              off;
        logic              pos;
        logic [CODE_W-1:0] code;
    } coil_drive_t;

    // index increment for one step strobe
    function automatic logic [IDX_W-1:0] step_size(res_t r);
        return IDX_W'((1 << (POS_W - 1)) >> r);
    endfunction

    // distance from the zero crossing -> level code
    function automatic logic [CODE_W-1:0] level_code(logic [X_W-1:0] x);
        if (x == '0)
            return '0;
        else if (x >= X_W'(CODE_MAX))
            return CODE_W'(CODE_MAX);
        else
            return CODE_W'(x + 1'b1);
    endfunction

endpackage

// File: rtl/ustep_index.sv
module ustep_index
    import ustep_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             step_i,
    input  logic             dir_i,
    input  logic             hold_i,
    input  res_t             res_i,
    output logic [IDX_W-1:0] idx_o
);

    logic [IDX_W-1:0] inc;
    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] nxt;

    always_comb begin
        inc  = step_size(res_i);
        base = idx_o & ~(inc - 1'b1);
        nxt  = base;
        if (step_i)
            nxt = dir_i ? base + inc : base - inc;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            idx_o <= '0;
        else if (!hold_i)
            idx_o <= nxt;
    end

    AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_i |=> $stable(idx_o)); // R9

    AST_ALIGNED: assert property (@(posedge clk_i) disable iff (rst_i)
        !hold_i |=> ((idx_o & (step_size($past(res_i)) - 1'b1)) == '0)); // R8

    AST_STEP_MOVES: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !hold_i) |=> (idx_o != $past(idx_o))); // R6

endmodule

// File: rtl/ustep_coil.sv
module ustep_coil
    import ustep_pkg::*;
#(
    parameter bit COS_PHASE = 1'b0   // 0: sine profile, 1: cosine profile
) (
    input  logic [QUAD_W-1:0] quad_i,
    input  logic [POS_W-1:0]  pos_i,
    output coil_drive_t       drv_o
);

    logic           rising;
    logic [X_W-1:0] x;

    always_comb begin
        rising     = (quad_i[0] == COS_PHASE);
        x          = rising ? {1'b0, pos_i} : X_W'(1 << POS_W) - {1'b0, pos_i};
        drv_o.code = level_code(x);
        drv_o.off  = (x == '0);
        drv_o.pos  = ~(quad_i[1] ^ (COS_PHASE & quad_i[0]));
    end

endmodule

// File: rtl/ustep_seq.sv
module ustep_seq
    import ustep_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       step_i,
    input  logic       dir_i,
    input  logic       hold_i,
    input  logic [1:0] res_i,
    output logic [3:0] a_code_o,
    output logic       a_pol_o,
    output logic       a_off_o,
    output logic [3:0] b_code_o,
    output logic       b_pol_o,
    output logic       b_off_o
);

    logic [IDX_W-1:0] idx;
    coil_drive_t      drv [2];

    ustep_index u_index (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .step_i (step_i),
        .dir_i  (dir_i),
        .hold_i (hold_i),
        .res_i  (res_t'(res_i)),
        .idx_o  (idx)
    );

    for (genvar g = 0; g < 2; g++) begin : g_coil
        ustep_coil #(.COS_PHASE(g[0])) u_coil (
            .quad_i (idx[IDX_W-1:POS_W]),
            .pos_i  (idx[POS_W-1:0]),
            .drv_o  (drv[g])
        );
    end

    assign a_code_o = drv[0].code;
    assign a_pol_o  = drv[0].pos;
    assign a_off_o  = drv[0].off;
    assign b_code_o = drv[1].code;
    assign b_pol_o  = drv[1].pos;
    assign b_off_o  = drv[1].off;

    AST_SINGLE_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        !(a_off_o && b_off_o)); // R4

    AST_A_OFF_B_FULL: assert property (@(posedge clk_i) disable iff (rst_i)
        a_off_o |-> (b_code_o == 4'hF)); // R4

    AST_B_OFF_A_FULL: assert property (@(posedge clk_i) disable iff (rst_i)
        b_off_o |-> (a_code_o == 4'hF)); // R4

    AST_NO_CODE_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
        (a_code_o != 4'd1) && (b_code_o != 4'd1)); // R11

    AST_A_POL_AT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (a_pol_o != $past(a_pol_o)) |-> (a_off_o || $past(a_off_o))); // R5

    AST_B_POL_AT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (b_pol_o != $past(b_pol_o)) |-> (b_off_o || $past(b_off_o))); // R5

endmodule

// File: tb/ustep_seq_tb_top.sv
module ustep_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step = 1'b0;
    logic       dir = 1'b1;
    logic       hold = 1'b0;
    logic [1:0] res = 2'b11;
    logic [3:0] a_code, b_code;
    logic       a_pol, a_off, b_pol, b_off;

    int total = 0;
    int bad = 0;
    int m_idx = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    ustep_seq dut_i (
        .clk_i(clk), .rst_i(rst), .step_i(step), .dir_i(dir), .hold_i(hold),
        .res_i(res),
        .a_code_o(a_code), .a_pol_o(a_pol), .a_off_o(a_off),
        .b_code_o(b_code), .b_pol_o(b_pol), .b_off_o(b_off)
    );

    // ---------------- reference model ----------------
    function automatic int inc_of(logic [1:0] r);
        case (r)
            2'b00: return 8;
            2'b01: return 4;
            2'b10: return 2;
            default: return 1;
        endcase
    endfunction

    // returns {off, pol, code}
    function automatic logic [5:0] model(int idx, bit cosine);
        int q = idx / 16;
        int p = idx % 16;
        bit rise = cosine ? (q == 1 || q == 3) : (q == 0 || q == 2);
        int x = rise ? p : 16 - p;
        bit neg = cosine ? (q == 1 || q == 2) : (q >= 2);
        int c;
        if (x == 0) c = 0;
        else if (x >= 15) c = 15;
        else c = x + 1;
        return {x == 0, !neg, 4'(c)};
    endfunction

    function automatic int align(int idx, logic [1:0] r);
        return idx - (idx % inc_of(r));
    endfunction

    // ---------------- check helpers ----------------
    task automatic chk(string req, string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got=%0d exp=%0d", req, what, got, exp);
        end
    endtask

    task automatic chk_model(string req);
        logic [5:0] ea = model(m_idx, 1'b0);
        logic [5:0] eb = model(m_idx, 1'b1);
        chk(req, $sformatf("A idx%0d", m_idx), {a_off, a_pol, a_code}, ea);
        chk(req, $sformatf("B idx%0d", m_idx), {b_off, b_pol, b_code}, eb);
        if (a_code == 4'd1 || b_code == 4'd1 || a_off != (a_code == 0) || b_off != (b_code == 0))
            chk("R11", "code/off consistency", 1, 0);
    endtask

    task automatic pulse(bit d);
        @(negedge clk);
        step = 1'b1;
        dir  = d;
        @(negedge clk);
        step = 1'b0;
        if (!hold) m_idx = (align(m_idx, res) + (d ? inc_of(res) : -inc_of(res)) + 64) % 64;
    endtask

    task automatic idle();
        @(negedge clk);
        if (!hold) m_idx = align(m_idx, res);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "A off in reset", a_off, 1);
        chk("R1", "B code in reset", b_code, 15);
        rst = 1'b0;
        m_idx = 0;
        @(negedge clk);
        chk("R1", "A code", a_code, 0);
        chk("R1", "A pol", a_pol, 1);
        chk("R1", "B code", b_code, 15);
        chk("R1", "B pol", b_pol, 1);
        chk("R1", "B off", b_off, 0);
    endtask

    task automatic t_latency();
        res = 2'b11;
        @(negedge clk);
        step = 1'b1;
        dir = 1'b1;
        #1;
        chk("R10", "A code before edge", a_code, 0);
        @(negedge clk);
        step = 1'b0;
        m_idx = 1;
        chk("R10", "A code after edge", a_code, 2);
        chk("R10", "B code after edge", b_code, 15);
        chk_model("R10");
    endtask

    task automatic t_fine_sweep();
        res = 2'b11;
        for (int i = 0; i < 64; i++) begin
            pulse(1'b1);
            chk_model("R2");
            if (m_idx % 16 == 8) begin
                chk("R3", "A midpoint", a_code, 9);
                chk("R3", "B midpoint", b_code, 9);
            end
            if (m_idx == 16) begin
                chk("R4", "B off at boundary", b_off, 1);
                chk("R4", "A full at boundary", a_code, 15);
                chk("R5", "B pol flipped", b_pol, 0);
            end
            if (m_idx == 40) chk("R5", "A pol q2", a_pol, 0);
        end
    endtask

    task automatic t_reverse_wrap();
        res = 2'b11;
        while (m_idx != 0) pulse(1'b1);
        pulse(1'b0);
        chk("R7", "A code idx63", a_code, 2);
        chk("R7", "A pol idx63", a_pol, 0);
        chk("R7", "B code idx63", b_code, 15);
        chk("R7", "B pol idx63", b_pol, 1);
        chk_model("R7");
        pulse(1'b1);
        chk_model("R7");
        chk("R7", "forward wrap to 0 A off", a_off, 1);
    endtask

    task automatic t_modes();
        for (int r = 0; r < 4; r++) begin
            res = 2'(r);
            idle();
            for (int k = 0; k < 5; k++) begin
                pulse(1'b1);
                chk_model("R6");
            end
            for (int k = 0; k < 2; k++) begin
                pulse(1'b0);
                chk_model("R6");
            end
        end
        res = 2'b00;
        while (m_idx != 0) pulse(1'b1);
        pulse(1'b1);
        chk("R6", "x8 step A mid", a_code, 9);
        chk("R6", "x8 step B mid", b_code, 9);
    endtask

    task automatic t_align();
        res = 2'b11;
        while (m_idx != 13) pulse(1'b1);
        res = 2'b01;
        #1;
        chk("R8", "no realign before edge A", a_code, 14);
        idle();
        chk("R8", "realigned to 12 A", a_code, 13);
        chk_model("R8");
        res = 2'b00;
        idle();
        chk("R8", "realigned to 8 A", a_code, 9);
        chk_model("R8");
    endtask

    task automatic t_hold();
        logic [11:0] snap;
        res = 2'b11;
        pulse(1'b1);
        pulse(1'b1);
        pulse(1'b1);
        snap = {a_off, a_pol, a_code, b_off, b_pol, b_code};
        @(negedge clk);
        hold = 1'b1;
        res = 2'b00;
        pulse(1'b1);
        pulse(1'b0);
        idle();
        chk("R9", "outputs frozen", {a_off, a_pol, a_code, b_off, b_pol, b_code}, snap);
        chk_model("R9");
        hold = 1'b0;
        idle();
        chk_model("R9");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_fine_sweep();
        t_reverse_wrap();
        t_modes();
        t_align();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule